// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer. It watches a counter value and its count direction, compares the counter with a software-written compare value, and produces a registered, active-high reference level. A pin output is derived from that reference through a selectable polarity inversion. The counter, prescaler, capture path and register bus sit outside the block and reach it only as plain ports.

A 3-bit mode field picks one of eight behaviours for the reference: hold, set on match, clear on match, toggle on match, force low, force high, and two edge-aligned PWM shapes that follow the count direction. An external clear input, when enabled, pulls the reference low. The compare value can be written straight through, or held in a preload register and moved to the active compare register only on an update strobe. A 2-bit channel-select field other than zero turns the channel into an input and shuts the compare logic off.

Top module: `oc_channel`

## Requirements
- R1: After reset the reference output is 0 and both the active compare value and the preload value are 0.
- R2: Mode 3'b001 drives the reference to 1, and mode 3'b010 drives it to 0, on the clock edge after a cycle in which the counter equals the active compare value; without a match the level holds.
- R3: Mode 3'b011 inverts the reference once on the edge after the first cycle of a match; further consecutive match cycles leave it unchanged, and a new match after a mismatch inverts it again.
- R4: Mode 3'b100 drives the reference to 0 and mode 3'b101 drives it to 1 on the next edge, whatever the counter.
- R5: Mode 3'b000 keeps the reference at its present level whatever the counter and compare value.
- R6: Mode 3'b110 computes a level that, with direction 0 (up), is 1 when counter < compare and 0 otherwise, and with direction 1 (down), is 0 when counter > compare and 1 otherwise.
- R7: Mode 3'b111 computes the inverse of the R6 level for the same counter, compare and direction.
- R8: In modes 3'b110/3'b111 the reference takes the computed PWM level on the next edge only when that level differs from its value in the previous cycle, or when the previous cycle's mode was 3'b000; otherwise it holds.
- R9: With clear-enable 1 and the external clear input 1, the reference goes to 0 on the next edge, overriding every mode.
- R10: With shadow-enable 1, a write updates only the preload value; the active compare value takes the preload value on the edge of an update strobe and is otherwise unchanged.
- R11: With shadow-enable 0, a write updates the active compare value on the next edge.
- R12: The pin output equals the reference XOR the polarity bit, combinationally.
- R13: With channel-select not equal to 2'b00, the reference goes to 0 on the next edge whatever the mode and clear inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Current timer counter value |
| cnt_dir | input | 1 | Count direction, 0 up, 1 down |
| upd_evt | input | 1 | Single-cycle update-event strobe |
| ext_clr | input | 1 | External clear level |
| cfg_mode | input | 3 | Compare mode select |
| cfg_chsel | input | 2 | Channel select, 2'b00 is output |
| cfg_clr_en | input | 1 | Enables the external clear |
| cfg_shadow_en | input | 1 | Enables the compare preload register |
| cfg_pol | input | 1 | Pin polarity, 1 inverts |
| cv_wr | input | 1 | Compare value write strobe |
| cv_wdata | input | CNT_W | Compare value write data |
| oc_ref | output | 1 | Registered active-high reference |
| oc_pin | output | 1 | Reference after polarity |

## Verification
Up ramps passing through the compare value separate set and clear on match from the hold mode, and a counter parked on the compare value for several cycles then left and re-entered tells a once-per-match toggle from a per-cycle one. The PWM modes are driven with both up and down ramps so that the strict and non-strict comparisons at the compare value itself are told apart by direction. Entering PWM from a forced level with an unchanged comparison shows that the reference holds until the comparison flips, while entering from the hold mode loads at once. A preload write followed by matches at the old and new values, before and after the update strobe, separates buffered from immediate writes.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [2:0] {
    OC_FROZEN = 3'b000,
    OC_SET    = 3'b001,
    OC_CLR    = 3'b010,
    OC_TOG    = 3'b011,
    OC_LOW    = 3'b100,
    OC_HIGH   = 3'b101,
    OC_PWM0   = 3'b110,
    OC_PWM1   = 3'b111
  } oc_mode_e;

  function automatic logic is_pwm(oc_mode_e m);
    return (m == OC_PWM0) || (m == OC_PWM1);
  endfunction

  // PWM level from the comparison results; width free so the bench can
  // restate it with plain integers.
  function automatic logic pwm_level(oc_mode_e m, logic down, logic lt, logic gt);
    logic base;
    base = down ? ~gt : lt;
    return (m == OC_PWM1) ? ~base : base;
  endfunction

endpackage

// File: rtl/oc_cmp_reg.sv
module oc_cmp_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shadow_en,
  input  logic             upd_evt,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] act
);

  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (wr) pre_q <= wdata;
      if (shadow_en) begin
        if (upd_evt) act_q <= pre_q;
      end else if (wr) begin
        act_q <= wdata;
      end
    end
  end

  assign act = act_q;

endmodule

// File: rtl/oc_compare.sv
module oc_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cv,
  input  logic             down,
  input  oc_pkg::oc_mode_e mode,
  output logic             match,
  output logic             match_rise,
  output logic             pwm_lvl,
  output logic             pwm_chg
);
  import oc_pkg::*;

  logic match_q;
  logic pwm_q;
  logic lt;
  logic gt;

  assign match      = (cnt == cv);
  assign lt         = (cnt < cv);
  assign gt         = (cnt > cv);
  assign pwm_lvl    = pwm_level(mode, down, lt, gt);
  assign match_rise = match & ~match_q;
  assign pwm_chg    = pwm_lvl ^ pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      match_q <= match;
      pwm_q   <= pwm_lvl;
    end
  end

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen (
  input  logic             clk,
  input  logic             rst_n,
  input  oc_pkg::oc_mode_e mode,
  input  logic             disabled,
  input  logic             clr_hit,
  input  logic             match,
  input  logic             match_rise,
  input  logic             pwm_lvl,
  input  logic             pwm_chg,
  output logic             ref_o
);
  import oc_pkg::*;

  logic     ref_q;
  logic     ref_d;
  oc_mode_e mode_q;
  logic     pwm_load;

  assign pwm_load = pwm_chg | (mode_q == OC_FROZEN);

  always_comb begin
    ref_d = ref_q;
    if (disabled || clr_hit) begin
      ref_d = 1'b0;
    end else begin
      unique case (mode)
        OC_FROZEN: ref_d = ref_q;
        OC_SET:    if (match) ref_d = 1'b1;
        OC_CLR:    if (match) ref_d = 1'b0;
        OC_TOG:    if (match_rise) ref_d = ~ref_q;
        OC_LOW:    ref_d = 1'b0;
        OC_HIGH:   ref_d = 1'b1;
        OC_PWM0,
        OC_PWM1:   if (pwm_load) ref_d = pwm_lvl;
        default:   ref_d = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      mode_q <= OC_FROZEN;
    end else begin
      ref_q  <= ref_d;
      mode_q <= mode;
    end
  end

  assign ref_o = ref_q;

endmodule

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_dir,
  input  logic             upd_evt,
  input  logic             ext_clr,
  input  logic [2:0]       cfg_mode,
  input  logic [1:0]       cfg_chsel,
  input  logic             cfg_clr_en,
  input  logic             cfg_shadow_en,
  input  logic             cfg_pol,
  input  logic             cv_wr,
  input  logic [CNT_W-1:0] cv_wdata,
  output logic             oc_ref,
  output logic             oc_pin
);
  import oc_pkg::*;

  oc_mode_e         mode;
  logic [CNT_W-1:0] cmp_act;
  logic             match;
  logic             match_rise;
  logic             pwm_lvl;
  logic             pwm_chg;
  logic             ch_disabled;
  logic             clr_hit;

  assign mode        = oc_mode_e'(cfg_mode);
  assign ch_disabled = (cfg_chsel != 2'b00);
  assign clr_hit     = cfg_clr_en & ext_clr;

  oc_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .shadow_en (cfg_shadow_en),
    .upd_evt   (upd_evt),
    .wr        (cv_wr),
    .wdata     (cv_wdata),
    .act       (cmp_act)
  );

  oc_compare #(.CNT_W(CNT_W)) u_cmpr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt_val),
    .cv         (cmp_act),
    .down       (cnt_dir),
    .mode       (mode),
    .match      (match),
    .match_rise (match_rise),
    .pwm_lvl    (pwm_lvl),
    .pwm_chg    (pwm_chg)
  );

  oc_ref_gen u_ref (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .disabled   (ch_disabled),
    .clr_hit    (clr_hit),
    .match      (match),
    .match_rise (match_rise),
    .pwm_lvl    (pwm_lvl),
    .pwm_chg    (pwm_chg),
    .ref_o      (oc_ref)
  );

  assign oc_pin = oc_ref ^ cfg_pol;

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cfg_mode,
  input logic [1:0]       cfg_chsel,
  input logic             cfg_clr_en,
  input logic             ext_clr,
  input logic             cfg_shadow_en,
  input logic             upd_evt,
  input logic             cv_wr,
  input logic [CNT_W-1:0] cv_wdata,
  input logic [CNT_W-1:0] cmp_act,
  input logic             oc_ref
);

  logic live;
  assign live = (cfg_chsel == 2'b00) && !(cfg_clr_en && ext_clr);

  assert_force_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cfg_mode == 3'b101) |=> oc_ref);

  assert_force_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'b100) |=> !oc_ref);

  assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cfg_mode == 3'b000) |=> $stable(oc_ref));

  assert_ext_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clr_en && ext_clr) |=> !oc_ref);

  assert_input_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chsel != 2'b00) |=> !oc_ref);

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_shadow_en && !upd_evt) |=> $stable(cmp_act));

  assert_direct_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_shadow_en && cv_wr) |=> (cmp_act == $past(cv_wdata)));

endmodule

bind oc_channel oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_mode      (cfg_mode),
  .cfg_chsel     (cfg_chsel),
  .cfg_clr_en    (cfg_clr_en),
  .ext_clr       (ext_clr),
  .cfg_shadow_en (cfg_shadow_en),
  .upd_evt       (upd_evt),
  .cv_wr         (cv_wr),
  .cv_wdata      (cv_wdata),
  .cmp_act       (cmp_act),
  .oc_ref        (oc_ref)
);

// File: tb/sim_oc_channel.sv
`timescale 1ns/1ps
module sim_oc_channel;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         cnt_dir = 1'b0;
  logic         upd_evt = 1'b0;
  logic         ext_clr = 1'b0;
  logic [2:0]   cfg_mode = 3'b000;
  logic [1:0]   cfg_chsel = 2'b00;
  logic         cfg_clr_en = 1'b0;
  logic         cfg_shadow_en = 1'b0;
  logic         cfg_pol = 1'b0;
  logic         cv_wr = 1'b0;
  logic [W-1:0] cv_wdata = '0;
  logic         oc_ref;
  logic         oc_pin;

  always #2.5 clk = ~clk;

  oc_channel #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_dir(cnt_dir),
    .upd_evt(upd_evt), .ext_clr(ext_clr), .cfg_mode(cfg_mode),
    .cfg_chsel(cfg_chsel), .cfg_clr_en(cfg_clr_en),
    .cfg_shadow_en(cfg_shadow_en), .cfg_pol(cfg_pol), .cv_wr(cv_wr),
    .cv_wdata(cv_wdata), .oc_ref(oc_ref), .oc_pin(oc_pin)
  );

  int checks = 0;
  int failures = 0;

  typedef struct { bit r; bit p; string tag; } exp_t;
  exp_t sb[$];

  // settings the test wants for the next step
  bit [2:0] t_mode = 0;
  bit [1:0] t_chsel = 0;
  bit       t_clr_en = 0, t_ext = 0, t_shadow = 0, t_pol = 0;

  // bench model state
  bit     m_ref = 0, m_prev_eq = 0, m_prev_pwm = 0;
  bit [2:0] m_prev_mode = 0;
  int     m_act = 0, m_pre = 0;

  task automatic check(string tag, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, int c, bit d, bit wr = 0, int wd = 0, bit upd = 0);
    bit eq, below, above, lvl, nref;
    int nact;
    @(negedge clk);
    cnt_val = W'(c); cnt_dir = d; cv_wr = wr; cv_wdata = W'(wd); upd_evt = upd;
    cfg_mode = t_mode; cfg_chsel = t_chsel; cfg_clr_en = t_clr_en;
    ext_clr = t_ext; cfg_shadow_en = t_shadow; cfg_pol = t_pol;
    eq = (c == m_act); below = (c < m_act); above = (c > m_act);
    if (d) lvl = !above; else lvl = below;
    if (t_mode == 3'd7) lvl = !lvl;
    nref = m_ref;
    if (t_chsel != 0 || (t_clr_en && t_ext)) nref = 0;
    else case (t_mode)
      3'd1: if (eq) nref = 1;
      3'd2: if (eq) nref = 0;
      3'd3: if (eq && !m_prev_eq) nref = !m_ref;
      3'd4: nref = 0;
      3'd5: nref = 1;
      3'd6, 3'd7: if (m_prev_mode == 0 || lvl != m_prev_pwm) nref = lvl;
      default: ;
    endcase
    nact = m_act;
    if (t_shadow) begin if (upd) nact = m_pre; end
    else if (wr) nact = wd;
    if (wr) m_pre = wd;
    m_act = nact; m_ref = nref; m_prev_eq = eq; m_prev_pwm = lvl; m_prev_mode = t_mode;
    sb.push_back('{r: nref, p: nref ^ t_pol, tag: tag});
    @(posedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, oc_ref, e.r, "ref");
        check(e.tag, oc_pin, e.p, "pin");
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    cfg_pol = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", oc_ref, 1'b0, "reset ref");
    check("R12", oc_pin, 1'b1, "reset pin inverted");
    @(negedge clk);
    cfg_pol = 1'b0;
    rst_n = 1'b1;
    // R1: compare value 0 after reset -> set mode matches at counter 0
    t_mode = 3'd1;
    step("R1", 3, 0); step("R1", 0, 0);
    t_mode = 3'd4; step("R4", 0, 0);
    // R11: direct write of 5
    t_mode = 3'd0; step("R11", 0, 0, 1, 5);
    t_mode = 3'd1;
    for (int i = 0; i < 8; i++) step("R2", i, 0);
    t_mode = 3'd2;
    for (int i = 0; i < 8; i++) step("R2", i, 0);
    // R3 toggle once per match run
    t_mode = 3'd3;
    step("R3", 4, 0); step("R3", 5, 0); step("R3", 5, 0); step("R3", 5, 0);
    step("R3", 6, 0); step("R3", 5, 0); step("R3", 5, 0);
    // R4 forced levels
    t_mode = 3'd5; step("R4", 1, 0); step("R4", 5, 0);
    t_mode = 3'd4; step("R4", 5, 0); step("R4", 9, 0);
    // R5 frozen holds both levels
    t_mode = 3'd0;
    for (int i = 3; i < 8; i++) step("R5", i, 0);
    t_mode = 3'd5; step("R4", 0, 0);
    t_mode = 3'd0;
    for (int i = 3; i < 8; i++) step("R5", i, 0);
    // R6 PWM0 up then down
    t_mode = 3'd6;
    for (int i = 0; i < 9; i++) step("R6", i, 0);
    for (int i = 8; i >= 0; i--) step("R6", i, 1);
    // R7 PWM1 up then down
    t_mode = 3'd7;
    for (int i = 0; i < 9; i++) step("R7", i, 0);
    for (int i = 8; i >= 0; i--) step("R7", i, 1);
    // R8 entering PWM from a forced level with unchanged comparison holds
    t_mode = 3'd4; step("R8", 0, 0); step("R8", 1, 0);
    t_mode = 3'd6; step("R8", 2, 0); step("R8", 3, 0); step("R8", 7, 0); step("R8", 1, 0);
    t_mode = 3'd5; step("R8", 9, 0);
    t_mode = 3'd7; step("R8", 8, 0); step("R8", 1, 0);
    t_mode = 3'd0; step("R8", 1, 0);
    t_mode = 3'd7; step("R8", 1, 0);
    // R12 polarity with toggling PWM
    t_pol = 1; t_mode = 3'd6;
    step("R12", 0, 0); step("R12", 6, 0); step("R12", 2, 0);
    t_pol = 0;
    // R9 external clear
    step("R9", 1, 0);
    t_clr_en = 1; t_ext = 1; step("R9", 1, 0); step("R9", 2, 0);
    t_ext = 0; step("R9", 3, 0);
    t_mode = 3'd5; t_ext = 1; step("R9", 3, 0);
    t_clr_en = 0; step("R9", 3, 0);
    t_ext = 0;
    // R10 shadow: write 8 into preload, active stays 5 until update
    t_shadow = 1; t_mode = 3'd5; step("R10", 0, 0, 1, 8);
    t_mode = 3'd2; step("R10", 8, 0); step("R10", 5, 0);
    t_mode = 3'd5; step("R10", 0, 0, 0, 0, 1);
    t_mode = 3'd2; step("R10", 5, 0); step("R10", 8, 0);
    t_shadow = 0;
    // R13 input channel disables the compare logic
    t_mode = 3'd5; step("R13", 0, 0);
    t_chsel = 2'b01; step("R13", 0, 0);
    t_chsel = 2'b11; t_pol = 1; step("R13", 0, 0);
    t_chsel = 2'b00; t_pol = 0; step("R13", 0, 0);
    repeat (3) @(posedge clk);
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule